// File: doc/BRIEF.md
# Two-Descriptor Transfer Cycle Sequencer

This block runs the transfer cycles of one channel from two descriptor slots, a primary and an alternate. Each slot holds a source address, a destination address, a beat count kept as count minus one, and a control word. The control word carries the cycle type, a batch exponent and one address step code for each side. A cycle is started with an enable pulse, and the caller chooses which slot runs first. The block then emits one beat at a time on a valid/done handshake. When the beats are used up it raises a one-cycle completion pulse and marks that slot as spent. The pulse is tagged with the slot that finished, so software knows which slot to refill.

Three cycle types run. A basic cycle moves one batch of beats for each accepted request. An auto-request cycle moves its whole count after a single request. A ping-pong cycle runs the other slot as soon as one finishes. The other slot can also be refilled as a basic or auto cycle, which makes it the final leg. If the other slot is left spent, the channel stops. The block also gives the memory addresses of this channel's two descriptor records, computed from a control-block base.

The state machine has five states:
- IDLE: the channel is off. An enable pulse moves it to LOAD.
- LOAD: the selected slot is copied into the working registers and the machine goes to WAIT. If the slot's cycle cannot run, the machine goes back to IDLE instead.
- WAIT: the machine waits for a request, then goes to XFER.
- XFER: one beat is offered. After the final beat the machine goes to DONE. When a batch ends in a cycle that is not auto-request, it goes back to WAIT.
- DONE: the completion pulse is raised. A ping-pong cycle goes to LOAD with the other slot selected. Any other cycle goes to IDLE.

Top module: `pp_desc_seq`

## Requirements
- R1: `desc_addr_pri` equals `cb_base` with its low 8 bits forced to zero, plus `chan_id` times 16. `desc_addr_alt` equals `desc_addr_pri` plus NCH times 16, which is 128 with the default NCH of 8.
- R2: After reset, `chan_en`, `beat_valid` and `done_pulse` are low, and both slots hold the stop cycle code.
- R3: Cycle codes are 0 stop, 1 basic, 2 auto-request and 3 ping-pong. Codes 4 to 7 are scatter-gather codes, which this block treats as stop. An `en_set` pulse while `chan_en` is low raises `chan_en` one cycle later and selects the alternate slot if `start_alt` is 1, otherwise the primary slot. If the selected slot cannot run, `chan_en` falls on the next cycle and no beat is issued.
- R4: The step codes are 0 for +1, 1 for +2, 2 for +4 and 3 for no step. Beat i uses the address src + i·step(src code) on the source side and dst + i·step(dst code) on the destination side.
- R5: A slot runs nminus1+1 beats. While `beat_valid` is high and `beat_done` is low, `beat_src` and `beat_dst` hold their values.
- R6: In a basic cycle, each accepted request yields min(2^rpow, beats left) beats. An rpow above 10 counts as 10.
- R7: In an auto-request cycle, one accepted request runs every beat of the slot.
- R8: When `req_src` is 0 the channel is memory-to-memory and a request is always present. When `req_src` is any other value, only a high `dreq` is a request.
- R9: `done_pulse` is high for exactly the cycle after the final beat's handshake, and `done_alt` shows the slot that finished (0 means primary). That slot's cycle code becomes stop.
- R10: When a ping-pong slot completes, the other slot is loaded next. If the other slot holds stop, `chan_en` falls. If it holds basic or auto, it runs and then the channel stops.
- R11: Completion of a basic or auto-request slot clears `chan_en` in the cycle after `done_pulse`.
- R12: A slot write changes only later loads, never the beats already running. A write to a slot in the same cycle as its completion clear wins over the clear. An `en_set` while `chan_en` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cb_base | input | AW | Control-block base address; the low 8 bits are ignored |
| chan_id | input | $clog2(NCH) | Channel number used for the descriptor addresses |
| req_src | input | SELW | Request source select; 0 means memory-to-memory |
| dreq | input | 1 | Peripheral request level |
| en_set | input | 1 | Enable pulse that starts the channel |
| start_alt | input | 1 | First slot to run: 1 alternate, 0 primary |
| wr_en | input | 1 | Slot write strobe |
| wr_alt | input | 1 | Slot to write: 1 alternate, 0 primary |
| wr_cycle | input | 3 | Cycle code to write |
| wr_rpow | input | 4 | Batch exponent to write |
| wr_src_inc | input | 2 | Source step code to write |
| wr_dst_inc | input | 2 | Destination step code to write |
| wr_nminus1 | input | CNTW | Beat count minus one to write |
| wr_src | input | AW | Source start address to write |
| wr_dst | input | AW | Destination start address to write |
| beat_done | input | 1 | The bus accepts the offered beat |
| chan_en | output | 1 | Channel enabled |
| active_alt | output | 1 | Slot currently selected |
| beat_valid | output | 1 | A beat is offered |
| beat_src | output | AW | Source address of the offered beat |
| beat_dst | output | AW | Destination address of the offered beat |
| done_pulse | output | 1 | One-cycle completion pulse |
| done_alt | output | 1 | Slot that completed: 1 alternate, 0 primary |
| desc_addr_pri | output | AW | Memory address of the primary descriptor record |
| desc_addr_alt | output | AW | Memory address of the alternate descriptor record |

## Verification
A wrong slot selection appears on the first completion pulse after the error, because `done_alt` carries the wrong value. The beat addresses show it one cycle after LOAD. A batch counter that is off shows up at the first request of a basic cycle: with no further requests, one beat too many or too few arrives within a few cycles. A lost or doubled completion clear shows up at the end of a ping-pong run. There is one completion too many or too few, and `chan_en` stays high when it should fall.

// File: rtl/pp_desc_pkg.sv
package pp_desc_pkg;

    // Width of the batch exponent field in a slot control word.
    localparam int unsigned RPOW_W = 4;

    // Cycle codes. Values 4..7 are accepted in a slot but never run.
    typedef enum logic [2:0] {
        CYC_STOP     = 3'd0,
        CYC_BASIC    = 3'd1,
        CYC_AUTO     = 3'd2,
        CYC_PINGPONG = 3'd3,
        CYC_MSG      = 3'd4,
        CYC_MSG_ALT  = 3'd5,
        CYC_PSG      = 3'd6,
        CYC_PSG_ALT  = 3'd7
    } cyc_e;

    // Address step codes.
    typedef enum logic [1:0] {
        STEP_1    = 2'd0,
        STEP_2    = 2'd1,
        STEP_4    = 2'd2,
        STEP_NONE = 2'd3
    } step_e;

    typedef struct packed {
        cyc_e                cyc;
        logic [RPOW_W-1:0]   rpow;
        step_e               sstep;
        step_e               dstep;
    } slot_ctrl_t;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_LOAD = 3'd1,
        S_WAIT = 3'd2,
        S_XFER = 3'd3,
        S_DONE = 3'd4
    } seq_state_e;

    function automatic logic cyc_runs(input cyc_e c);
        return (c == CYC_BASIC) || (c == CYC_AUTO) || (c == CYC_PINGPONG);
    endfunction

endpackage

// File: rtl/pp_desc_addr.sv
module pp_desc_addr #(
    parameter int unsigned AW  = 32,
    parameter int unsigned NCH = 8,
    localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [AW-1:0]  cb_base,
    input  logic [CHW-1:0] chan_id,
    output logic [AW-1:0]  addr_pri,
    output logic [AW-1:0]  addr_alt
);
    localparam int unsigned REC_BYTES = 16;
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(255);
    localparam logic [AW-1:0] ALT_OFS    = AW'(NCH * REC_BYTES);

    logic [AW-1:0] chan_ofs;

    always_comb begin
        chan_ofs = AW'(chan_id) << 4;
        addr_pri = (cb_base & ALIGN_MASK) + chan_ofs;
        addr_alt = addr_pri + ALT_OFS;
    end
endmodule

// File: rtl/pp_desc_store.sv
module pp_desc_store
    import pp_desc_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned CNTW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_alt,
    input  slot_ctrl_t       wr_ctrl,
    input  logic [CNTW-1:0]  wr_nm1,
    input  logic [AW-1:0]    wr_src,
    input  logic [AW-1:0]    wr_dst,
    input  logic             clr_en,
    input  logic             clr_alt,
    input  logic             rd_alt,
    output slot_ctrl_t       rd_ctrl,
    output logic [CNTW-1:0]  rd_nm1,
    output logic [AW-1:0]    rd_src,
    output logic [AW-1:0]    rd_dst
);
    localparam int unsigned NSLOT = 2;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        slot_ctrl_t      ctrl;
        logic [CNTW-1:0] nm1;
        logic [AW-1:0]   src;
        logic [AW-1:0]   dst;
        logic            hit_wr;
        logic            hit_clr;

        assign hit_wr  = wr_en  && (wr_alt  == 1'(g));
        assign hit_clr = clr_en && (clr_alt == 1'(g));

        // A software write takes precedence over the completion clear.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ctrl <= slot_ctrl_t'('0);
                nm1  <= '0;
                src  <= '0;
                dst  <= '0;
            end else if (hit_wr) begin
                ctrl <= wr_ctrl;
                nm1  <= wr_nm1;
                src  <= wr_src;
                dst  <= wr_dst;
            end else if (hit_clr) begin
                ctrl.cyc <= CYC_STOP;
            end
        end
    end

    always_comb begin
        if (rd_alt) begin
            rd_ctrl = g_slot[1].ctrl;
            rd_nm1  = g_slot[1].nm1;
            rd_src  = g_slot[1].src;
            rd_dst  = g_slot[1].dst;
        end else begin
            rd_ctrl = g_slot[0].ctrl;
            rd_nm1  = g_slot[0].nm1;
            rd_src  = g_slot[0].src;
            rd_dst  = g_slot[0].dst;
        end
    end
endmodule

// File: rtl/pp_desc_fsm.sv
module pp_desc_fsm
    import pp_desc_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned CNTW = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             start_alt,
    input  logic             req,
    input  slot_ctrl_t       rd_ctrl,
    input  logic [CNTW-1:0]  rd_nm1,
    input  logic [AW-1:0]    rd_src,
    input  logic [AW-1:0]    rd_dst,
    input  logic             beat_done,
    output logic             sel_alt,
    output logic             chan_en,
    output logic             beat_valid,
    output logic [AW-1:0]    beat_src,
    output logic [AW-1:0]    beat_dst,
    output logic             done_pulse,
    output logic             clr_en
);
    seq_state_e      st, nxt;
    logic            sel_q;
    logic            en_q;
    slot_ctrl_t      wk_ctrl;
    logic [CNTW-1:0] wk_rem;
    logic [CNTW-1:0] wk_batch;
    logic [AW-1:0]   wk_src;
    logic [AW-1:0]   wk_dst;
    logic [CNTW-1:0] batch_ld;
    logic [AW-1:0]   src_step;
    logic [AW-1:0]   dst_step;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // Transitions.
    always_comb begin
        nxt = st;
        unique case (st)
            S_IDLE: if (en_set) nxt = S_LOAD;
            S_LOAD: nxt = cyc_runs(rd_ctrl.cyc) ? S_WAIT : S_IDLE;
            S_WAIT: if (req) nxt = S_XFER;
            S_XFER: begin
                if (beat_done) begin
                    if (wk_rem == '0)
                        nxt = S_DONE;
                    else if ((wk_batch == '0) && (wk_ctrl.cyc != CYC_AUTO))
                        nxt = S_WAIT;
                end
            end
            S_DONE: nxt = (wk_ctrl.cyc == CYC_PINGPONG) ? S_LOAD : S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // Batch size minus one, exponent capped at CNTW.
    always_comb begin
        if (wk_ctrl.rpow >= RPOW_W'(CNTW)) batch_ld = '1;
        else                               batch_ld = ~({CNTW{1'b1}} << wk_ctrl.rpow);
        src_step = (wk_ctrl.sstep == STEP_NONE) ? '0 : (AW'(1) << wk_ctrl.sstep);
        dst_step = (wk_ctrl.dstep == STEP_NONE) ? '0 : (AW'(1) << wk_ctrl.dstep);
    end

    // Working registers and channel enable.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            en_q     <= 1'b0;
            wk_ctrl  <= slot_ctrl_t'('0);
            wk_rem   <= '0;
            wk_batch <= '0;
            wk_src   <= '0;
            wk_dst   <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (en_set) begin
                        en_q  <= 1'b1;
                        sel_q <= start_alt;
                    end
                end
                S_LOAD: begin
                    if (cyc_runs(rd_ctrl.cyc)) begin
                        wk_ctrl <= rd_ctrl;
                        wk_rem  <= rd_nm1;
                        wk_src  <= rd_src;
                        wk_dst  <= rd_dst;
                    end else begin
                        en_q <= 1'b0;
                    end
                end
                S_WAIT: begin
                    if (req) wk_batch <= batch_ld;
                end
                S_XFER: begin
                    if (beat_done) begin
                        wk_src <= wk_src + src_step;
                        wk_dst <= wk_dst + dst_step;
                        if (wk_rem != '0)   wk_rem   <= wk_rem - 1'b1;
                        if (wk_batch != '0) wk_batch <= wk_batch - 1'b1;
                    end
                end
                S_DONE: begin
                    if (wk_ctrl.cyc == CYC_PINGPONG) sel_q <= ~sel_q;
                    else                             en_q  <= 1'b0;
                end
                default: en_q <= 1'b0;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        sel_alt    = sel_q;
        chan_en    = en_q;
        beat_valid = (st == S_XFER);
        beat_src   = wk_src;
        beat_dst   = wk_dst;
        done_pulse = (st == S_DONE);
        clr_en     = (st == S_DONE);
    end
endmodule

// File: rtl/pp_desc_seq.sv
module pp_desc_seq
    import pp_desc_pkg::*;
#(
    parameter int unsigned AW   = 32,
    parameter int unsigned NCH  = 8,
    parameter int unsigned CNTW = 10,
    parameter int unsigned SELW = 6,
    localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     cb_base,
    input  logic [CHW-1:0]    chan_id,
    input  logic [SELW-1:0]   req_src,
    input  logic              dreq,
    input  logic              en_set,
    input  logic              start_alt,
    input  logic              wr_en,
    input  logic              wr_alt,
    input  logic [2:0]        wr_cycle,
    input  logic [RPOW_W-1:0] wr_rpow,
    input  logic [1:0]        wr_src_inc,
    input  logic [1:0]        wr_dst_inc,
    input  logic [CNTW-1:0]   wr_nminus1,
    input  logic [AW-1:0]     wr_src,
    input  logic [AW-1:0]     wr_dst,
    input  logic              beat_done,
    output logic              chan_en,
    output logic              active_alt,
    output logic              beat_valid,
    output logic [AW-1:0]     beat_src,
    output logic [AW-1:0]     beat_dst,
    output logic              done_pulse,
    output logic              done_alt,
    output logic [AW-1:0]     desc_addr_pri,
    output logic [AW-1:0]     desc_addr_alt
);
    slot_ctrl_t      wr_ctrl;
    slot_ctrl_t      rd_ctrl;
    logic [CNTW-1:0] rd_nm1;
    logic [AW-1:0]   rd_src;
    logic [AW-1:0]   rd_dst;
    logic            sel_alt;
    logic            clr_en;
    logic            req;

    always_comb begin
        wr_ctrl.cyc   = cyc_e'(wr_cycle);
        wr_ctrl.rpow  = wr_rpow;
        wr_ctrl.sstep = step_e'(wr_src_inc);
        wr_ctrl.dstep = step_e'(wr_dst_inc);
        // Source select zero: memory-to-memory, request always present.
        req           = (req_src == '0) || dreq;
        active_alt    = sel_alt;
        done_alt      = sel_alt;
    end

    pp_desc_addr #(.AW(AW), .NCH(NCH)) u_addr (
        .cb_base  (cb_base),
        .chan_id  (chan_id),
        .addr_pri (desc_addr_pri),
        .addr_alt (desc_addr_alt)
    );

    pp_desc_store #(.AW(AW), .CNTW(CNTW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_alt  (wr_alt),
        .wr_ctrl (wr_ctrl),
        .wr_nm1  (wr_nminus1),
        .wr_src  (wr_src),
        .wr_dst  (wr_dst),
        .clr_en  (clr_en),
        .clr_alt (sel_alt),
        .rd_alt  (sel_alt),
        .rd_ctrl (rd_ctrl),
        .rd_nm1  (rd_nm1),
        .rd_src  (rd_src),
        .rd_dst  (rd_dst)
    );

    pp_desc_fsm #(.AW(AW), .CNTW(CNTW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_set     (en_set),
        .start_alt  (start_alt),
        .req        (req),
        .rd_ctrl    (rd_ctrl),
        .rd_nm1     (rd_nm1),
        .rd_src     (rd_src),
        .rd_dst     (rd_dst),
        .beat_done  (beat_done),
        .sel_alt    (sel_alt),
        .chan_en    (chan_en),
        .beat_valid (beat_valid),
        .beat_src   (beat_src),
        .beat_dst   (beat_dst),
        .done_pulse (done_pulse),
        .clr_en     (clr_en)
    );
endmodule

// File: rtl/pp_desc_seq_chk.sv
module pp_desc_seq_chk #(
    parameter int unsigned AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en_set,
    input logic          chan_en,
    input logic          beat_valid,
    input logic          beat_done,
    input logic [AW-1:0] beat_src,
    input logic [AW-1:0] beat_dst,
    input logic          done_pulse
);
    assert_beat_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> chan_en);

    assert_enable_from_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(chan_en) |-> $past(en_set));

    assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_done) |=> (beat_valid && $stable(beat_src) && $stable(beat_dst)));

    assert_done_after_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> $past(beat_valid && beat_done));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);

    assert_done_no_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> !beat_valid);
endmodule

bind pp_desc_seq pp_desc_seq_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_set     (en_set),
    .chan_en    (chan_en),
    .beat_valid (beat_valid),
    .beat_done  (beat_done),
    .beat_src   (beat_src),
    .beat_dst   (beat_dst),
    .done_pulse (done_pulse)
);

// File: tb/pp_desc_seq_tb.sv
`timescale 1ns/1ps
module pp_desc_seq_tb;
    localparam int AW = 32, NCH = 8, CNTW = 10, SELW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   cb_base = '0;
    logic [2:0]      chan_id = '0;
    logic [SELW-1:0] req_src = '0;
    logic            dreq = 1'b0, en_set = 1'b0, start_alt = 1'b0;
    logic            wr_en = 1'b0, wr_alt = 1'b0;
    logic [2:0]      wr_cycle = '0;
    logic [3:0]      wr_rpow = '0;
    logic [1:0]      wr_src_inc = '0, wr_dst_inc = '0;
    logic [CNTW-1:0] wr_nminus1 = '0;
    logic [AW-1:0]   wr_src = '0, wr_dst = '0;
    logic            beat_done = 1'b0;
    logic            chan_en, active_alt, beat_valid, done_pulse, done_alt;
    logic [AW-1:0]   beat_src, beat_dst, desc_addr_pri, desc_addr_alt;

    always #2.5 clk = ~clk;

    pp_desc_seq #(.AW(AW), .NCH(NCH), .CNTW(CNTW), .SELW(SELW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cb_base(cb_base), .chan_id(chan_id),
        .req_src(req_src), .dreq(dreq), .en_set(en_set), .start_alt(start_alt),
        .wr_en(wr_en), .wr_alt(wr_alt), .wr_cycle(wr_cycle), .wr_rpow(wr_rpow),
        .wr_src_inc(wr_src_inc), .wr_dst_inc(wr_dst_inc), .wr_nminus1(wr_nminus1),
        .wr_src(wr_src), .wr_dst(wr_dst), .beat_done(beat_done),
        .chan_en(chan_en), .active_alt(active_alt), .beat_valid(beat_valid),
        .beat_src(beat_src), .beat_dst(beat_dst), .done_pulse(done_pulse),
        .done_alt(done_alt), .desc_addr_pri(desc_addr_pri), .desc_addr_alt(desc_addr_alt)
    );

    int n_chk = 0, n_err = 0, cyc = 0, hold_bad = 0;
    logic [AW-1:0] bsrc_q[$], bdst_q[$];
    int            bcyc_q[$], dcyc_q[$];
    bit            dalt_q[$];

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] stp(input logic [1:0] c);
        return (c == 2'd3) ? '0 : (AW'(1) << c);
    endfunction

    // Bus responder and monitor, acting away from the active edge.
    initial begin
        logic          stalled = 1'b0;
        logic [AW-1:0] ps = '0, pd = '0;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n && beat_valid) begin
                bit bd;
                if (stalled && (beat_src != ps || beat_dst != pd)) hold_bad++;
                bd = ($urandom % 4) != 0;
                beat_done = bd;
                if (bd) begin
                    bsrc_q.push_back(beat_src);
                    bdst_q.push_back(beat_dst);
                    bcyc_q.push_back(cyc);
                end
                stalled = !bd;
                ps = beat_src;
                pd = beat_dst;
            end else begin
                beat_done = 1'b0;
                stalled = 1'b0;
            end
            if (rst_n && done_pulse) begin
                dalt_q.push_back(done_alt);
                dcyc_q.push_back(cyc);
            end
        end
    end

    task automatic clr_mon();
        bsrc_q.delete(); bdst_q.delete(); bcyc_q.delete();
        dalt_q.delete(); dcyc_q.delete();
    endtask

    task automatic wr(input bit alt, input logic [2:0] cy, input logic [3:0] rp,
                      input logic [1:0] si, input logic [1:0] di, input int nm1,
                      input logic [AW-1:0] s, input logic [AW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_alt = alt; wr_cycle = cy; wr_rpow = rp;
        wr_src_inc = si; wr_dst_inc = di; wr_nminus1 = CNTW'(nm1); wr_src = s; wr_dst = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic enable(input bit alt);
        @(negedge clk);
        en_set = 1'b1; start_alt = alt;
        @(negedge clk);
        en_set = 1'b0;
        chk(chan_en == 1'b1, "R3 enable rises", chan_en, 1);
    endtask

    task automatic pulse_req();
        @(negedge clk); dreq = 1'b1;
        @(negedge clk); dreq = 1'b0;
    endtask

    task automatic wait_off(input string req);
        int k = 0;
        while (chan_en && k < 5000) begin @(negedge clk); k++; end
        chk(!chan_en, req, chan_en, 0);
    endtask

    task automatic chk_beats(input int first, input int n, input logic [AW-1:0] s,
                             input logic [AW-1:0] d, input logic [1:0] si,
                             input logic [1:0] di, input string req);
        bit ok = 1'b1;
        logic [AW-1:0] a = '0, e = '0;
        for (int i = 0; i < n; i++) begin
            if (first + i < bsrc_q.size()) begin
                logic [AW-1:0] es = s + AW'(i) * stp(si);
                logic [AW-1:0] ed = d + AW'(i) * stp(di);
                if (ok && bsrc_q[first+i] != es) begin ok = 0; a = bsrc_q[first+i]; e = es; end
                if (ok && bdst_q[first+i] != ed) begin ok = 0; a = bdst_q[first+i]; e = ed; end
            end
        end
        chk(ok, req, a, e);
    endtask

    task automatic chk_done_seq(input int n, input bit [2:0] alts, input string req);
        chk(dalt_q.size() == n, req, dalt_q.size(), n);
        for (int i = 0; i < n; i++)
            if (i < dalt_q.size())
                chk(dalt_q[i] == alts[i], req, dalt_q[i], alts[i]);
    endtask

    task automatic chk_done_time(input string req);
        if (dcyc_q.size() > 0 && bcyc_q.size() > 0)
            chk(dcyc_q[dcyc_q.size()-1] == bcyc_q[bcyc_q.size()-1] + 1, req,
                dcyc_q[dcyc_q.size()-1], bcyc_q[bcyc_q.size()-1] + 1);
        else
            chk(1'b0, req, dcyc_q.size(), 1);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        chk(chan_en == 0, "R2 chan_en reset", chan_en, 0);
        chk(beat_valid == 0, "R2 beat_valid reset", beat_valid, 0);
        chk(done_pulse == 0, "R2 done_pulse reset", done_pulse, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: descriptor record addresses.
        for (int i = 0; i < 6; i++) begin
            logic [AW-1:0] eb;
            cb_base = $urandom;
            chan_id = 3'($urandom);
            #1;
            eb = (cb_base & ~AW'(255)) + AW'(chan_id) * 16;
            chk(desc_addr_pri == eb, "R1 primary address", desc_addr_pri, eb);
            chk(desc_addr_alt == eb + 128, "R1 alternate address", desc_addr_alt, eb + 128);
        end

        // R2/R3: slots reset to stop, channel drops with no beats.
        clr_mon();
        enable(1'b0);
        repeat (3) @(negedge clk);
        chk(!chan_en, "R2 stop after reset", chan_en, 0);
        chk(bsrc_q.size() == 0, "R2 no beats from stop slot", bsrc_q.size(), 0);

        // R3: scatter-gather code treated as stop.
        wr(1'b0, 3'd4, 4'd0, 2'd2, 2'd2, 3, 32'h100, 32'h200);
        enable(1'b0);
        repeat (3) @(negedge clk);
        chk(!chan_en, "R3 scatter-gather code stops", chan_en, 0);
        chk(bsrc_q.size() == 0, "R3 no beats for code 4", bsrc_q.size(), 0);

        // R6/R8/R12: basic cycle with peripheral requests, batch of 2.
        clr_mon();
        req_src = 6'd5;
        wr(1'b0, 3'd1, 4'd1, 2'd2, 2'd3, 4, 32'h1000, 32'h4000_0000);
        enable(1'b0);
        repeat (6) @(negedge clk);
        chk(bsrc_q.size() == 0, "R8 no request no beats", bsrc_q.size(), 0);
        pulse_req();
        repeat (30) @(negedge clk);
        chk(bsrc_q.size() == 2, "R6 first batch", bsrc_q.size(), 2);
        wr(1'b0, 3'd1, 4'd1, 2'd0, 2'd0, 4, 32'h9000, 32'h9900);
        @(negedge clk); en_set = 1'b1; start_alt = 1'b1;
        @(negedge clk); en_set = 1'b0;
        pulse_req();
        repeat (30) @(negedge clk);
        chk(bsrc_q.size() == 4, "R6 second batch", bsrc_q.size(), 4);
        pulse_req();
        wait_off("R11 basic done clears enable");
        chk(bsrc_q.size() == 5, "R5 beat count nminus1+1", bsrc_q.size(), 5);
        chk_beats(0, 5, 32'h1000, 32'h4000_0000, 2'd2, 2'd3, "R12 working copy kept / R4 steps");
        chk_done_seq(1, 3'b000, "R12 en_set ignored while enabled / R9 done slot");
        chk_done_time("R9 done one cycle after last beat");
        chk(hold_bad == 0, "R5 stalled beat holds", hold_bad, 0);

        // R9: finished slot was cleared to stop.
        clr_mon();
        enable(1'b0);
        repeat (3) @(negedge clk);
        chk(!chan_en && bsrc_q.size() == 0, "R9 finished slot cleared", bsrc_q.size(), 0);

        // R7: auto-request on the alternate slot.
        clr_mon();
        wr(1'b1, 3'd2, 4'd0, 2'd1, 2'd0, 6, 32'h2000, 32'h3000);
        enable(1'b1);
        repeat (4) @(negedge clk);
        pulse_req();
        wait_off("R7 auto completes");
        chk(bsrc_q.size() == 7, "R7 one request runs all beats", bsrc_q.size(), 7);
        chk_beats(0, 7, 32'h2000, 32'h3000, 2'd1, 2'd0, "R4 half and byte steps");
        chk_done_seq(1, 3'b001, "R3 start on alternate");

        // R10: ping-pong without refill.
        clr_mon();
        req_src = 6'd0;
        wr(1'b0, 3'd3, 4'd1, 2'd2, 2'd2, 2, 32'h5000, 32'h6000);
        wr(1'b1, 3'd3, 4'd2, 2'd0, 2'd1, 3, 32'h7000, 32'h8000);
        enable(1'b0);
        wait_off("R10 ping-pong stops on spent slot");
        chk(bsrc_q.size() == 7, "R10 beats of both slots", bsrc_q.size(), 7);
        chk_beats(0, 3, 32'h5000, 32'h6000, 2'd2, 2'd2, "R10 primary leg");
        chk_beats(3, 4, 32'h7000, 32'h8000, 2'd0, 2'd1, "R10 alternate leg");
        chk_done_seq(2, 3'b010, "R10 done order");

        // R10/R12: refill primary as last leg on the same cycle as its clear.
        clr_mon();
        wr(1'b0, 3'd3, 4'd0, 2'd2, 2'd2, 1, 32'hA000, 32'hB000);
        wr(1'b1, 3'd3, 4'd0, 2'd2, 2'd2, 5, 32'hC000, 32'hD000);
        enable(1'b0);
        begin
            int k = 0;
            while (!done_pulse && k < 2000) begin @(negedge clk); k++; end
        end
        wr_en = 1'b1; wr_alt = 1'b0; wr_cycle = 3'd1; wr_rpow = 4'd3;
        wr_src_inc = 2'd0; wr_dst_inc = 2'd3; wr_nminus1 = 10'd2;
        wr_src = 32'hE000; wr_dst = 32'hF000;
        @(negedge clk); wr_en = 1'b0;
        wait_off("R10 last leg ends channel");
        chk(bsrc_q.size() == 11, "R12 write wins over clear", bsrc_q.size(), 11);
        chk_beats(8, 3, 32'hE000, 32'hF000, 2'd0, 2'd3, "R10 refilled leg addresses");
        chk_done_seq(3, 3'b010, "R10 done order with refill");

        // Random basic/auto runs, memory-to-memory.
        for (int it = 0; it < 40; it++) begin
            int n = 1 + ($urandom % 24);
            bit alt = 1'($urandom);
            logic [2:0] cy = ($urandom % 2) ? 3'd1 : 3'd2;
            logic [3:0] rp = 4'($urandom % 12);
            logic [1:0] si = 2'($urandom), di = 2'($urandom);
            logic [AW-1:0] s = $urandom, d = $urandom;
            clr_mon();
            wr(alt, cy, rp, si, di, n - 1, s, d);
            enable(alt);
            wait_off("R11 random run ends");
            chk(bsrc_q.size() == n, "R5 random beat count", bsrc_q.size(), n);
            chk_beats(0, n, s, d, si, di, "R4 random addresses");
            chk_done_seq(1, {2'b00, alt}, "R9 random done slot");
            chk_done_time("R9 random done timing");
        end
        chk(hold_bad == 0, "R5 stalled beats held", hold_bad, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule